// File: doc/BRIEF.md
# Split Dual 8-bit Reload Timer

This block is a timer in its split configuration: two independent 8-bit up-counters, a low half and a high half, each reloading from its own reload register when it rolls over from 0xFF to 0x00. Each half chooses its own count clock. It can count on every system clock, on a tick every 12 system clocks, or on a tick every 8 rising edges of a synchronized external clock input. All logic runs in the one system clock domain, driven by one-cycle count-enable ticks.

Each rollover sets a sticky flag for that half and emits a one-cycle pulse for neighbouring converter and serial-bus peripherals. A level interrupt request combines the flags under two enables. A small address/data register port reads and writes the control bits, the clock selects, the counters and the reload values. The run bit gates only the high half. The low half counts whenever split mode is active.

Top module: `split_reload_timer`

## Requirements
- R1: Counting happens only when CTRL.split (bit 0) is 1 and CTRL.capture (bit 1) is 0. Otherwise both counters hold their values.
- R2: When a half counts at 0xFF, it loads its own reload register (low half from RLD_LO at address 4, high half from RLD_HI at address 5). In the cycle after that edge, its overflow pulse output is high for exactly that one cycle.
- R3: CTRL.run (bit 2) gates only the high half. The low half counts whenever R1 allows, whatever run is.
- R4: CLKSEL (address 1) bit 0 selects the low half's clock and bit 1 selects the high half's clock. A 1 makes that half count on every system clock.
- R5: When a half's CLKSEL bit is 0 and CTRL.ext_sel (bit 3) is 0, the half counts once every 12 system clocks.
- R6: When a half's CLKSEL bit is 0 and CTRL.ext_sel is 1, the half counts once per 8 rising edges of ext_clk, after a two-stage synchronizer.
- R7: CTRL bit 6 (low flag) and bit 7 (high flag) are set by their half's overflow. Hardware never clears them, and a CTRL write stores the written flag bits. An overflow in the same cycle as a clearing write leaves the flag set.
- R8: irq equals (high flag OR (low flag AND CTRL.lo_irq_en, bit 4)) AND CTRL.irq_en (bit 5).
- R9: A register write to CNT_LO (address 2) or CNT_HI (address 3) in a cycle that also has a count tick stores the written value. The tick is lost.
- R10: After reset all registers read 0, irq is 0 and both pulses are 0. reg_rdata shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| ext_clk | input | 1 | Asynchronous external clock |
| irq | output | 1 | Interrupt request level |
| lo_ovf_pulse | output | 1 | One-cycle low-half overflow pulse |
| hi_ovf_pulse | output | 1 | One-cycle high-half overflow pulse |

## Verification
The bench walks counters across the 0xFF rollover with different reload values, run settings and interrupt enables. A model of the rollover rule checks the counts, flags, pulse counts and irq. A design that reloaded from the wrong register, let the run bit stop the low half, or raised irq on a low overflow without its enable would miss these values. Directed cases cover the rest. A counter write that collides with a tick must keep the written value, not value plus one. A capture-enabled or non-split setting must freeze both counters. A flag must survive dozens of cycles until it is written back to 0. Exactly two increments are expected over 24 clocks of the divide-by-12 source and over 16 external edges, so a miscounted prescaler or a missing synchronizer edge detector shows up as a wrong count.

// File: rtl/srt_pkg.sv
package srt_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CLKSEL = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd5;

    // control register, bit 7 down to bit 0
    typedef struct packed {
        logic flag_hi;
        logic flag_lo;
        logic irq_en;
        logic lo_irq_en;
        logic ext_sel;
        logic run_hi;
        logic cap_en;
        logic split_en;
    } ctrl_t;
endpackage

// File: rtl/srt_prescale.sv
module srt_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = (st_q.cnt == LAST);
endmodule

// File: rtl/srt_extdiv.sv
module srt_extdiv #(
    parameter int SYNC = 2,
    parameter int DIV  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic            prev;
        logic [CW-1:0]   cnt;
    } st_t;

    st_t  st_d, st_q;
    logic rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC-2:0], ext_in};
        st_d.prev = st_q.sync[SYNC-1];
        rise      = st_q.sync[SYNC-1] & ~st_q.prev;
        if (rise) begin
            if (st_q.cnt == LAST) st_d.cnt = '0;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = rise & (st_q.cnt == LAST);
endmodule

// File: rtl/srt_half.sv
module srt_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] rld,
    output logic [W-1:0] cnt,
    output logic         ovf_evt,
    output logic         ovf_pulse
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        ovf_evt    = 1'b0;
        st_d.pulse = 1'b0;
        if (wr) begin
            st_d.cnt = wdata;              // write wins over a tick
        end else if (cnt_en) begin
            if (st_q.cnt == TOP) begin
                st_d.cnt   = rld;
                st_d.pulse = 1'b1;
                ovf_evt    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign ovf_pulse = st_q.pulse;
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
    import srt_pkg::*;
#(
    parameter int W         = 8,
    parameter int PRE_DIV   = 12,
    parameter int EXT_DIV   = 8,
    parameter int EXT_SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              ext_clk,
    output logic              irq,
    output logic              lo_ovf_pulse,
    output logic              hi_ovf_pulse
);
    localparam int NH = 2;   // index 0 = low half, 1 = high half

    typedef struct packed {
        ctrl_t                ctrl;
        logic [NH-1:0]        fast;
        logic [NH-1:0][W-1:0] rld;
    } st_t;

    st_t st_d, st_q;

    logic                 pre_tick, ext_tick, split_active;
    logic [NH-1:0]        src_tick, cnt_en, cnt_wr, ovf_evt, ovf_pulse;
    logic [NH-1:0][W-1:0] cnt;

    srt_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(pre_tick)
    );

    srt_extdiv #(.SYNC(EXT_SYNC), .DIV(EXT_DIV)) u_ext (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_clk), .tick(ext_tick)
    );

    assign split_active = st_q.ctrl.split_en & ~st_q.ctrl.cap_en;

    for (genvar g = 0; g < NH; g++) begin : g_half
        localparam logic [ADDR_W-1:0] CNT_ADDR = (g == 0) ? A_CNT_LO : A_CNT_HI;
        logic gate;
        assign gate        = (g == 0) ? 1'b1 : st_q.ctrl.run_hi;
        assign src_tick[g] = st_q.fast[g] ? 1'b1
                           : (st_q.ctrl.ext_sel ? ext_tick : pre_tick);
        assign cnt_en[g]   = split_active & gate & src_tick[g];
        assign cnt_wr[g]   = reg_wr & (reg_addr == CNT_ADDR);

        srt_half #(.W(W)) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_en   (cnt_en[g]),
            .wr       (cnt_wr[g]),
            .wdata    (reg_wdata),
            .rld      (st_q.rld[g]),
            .cnt      (cnt[g]),
            .ovf_evt  (ovf_evt[g]),
            .ovf_pulse(ovf_pulse[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL:   st_d.ctrl   = ctrl_t'(reg_wdata[7:0]);
                A_CLKSEL: st_d.fast   = reg_wdata[NH-1:0];
                A_RLD_LO: st_d.rld[0] = reg_wdata;
                A_RLD_HI: st_d.rld[1] = reg_wdata;
                default: ;
            endcase
        end
        // hardware set has priority over a same-cycle clear
        if (ovf_evt[0]) st_d.ctrl.flag_lo = 1'b1;
        if (ovf_evt[1]) st_d.ctrl.flag_hi = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:   reg_rdata[7:0]    = st_q.ctrl;
            A_CLKSEL: reg_rdata[NH-1:0] = st_q.fast;
            A_CNT_LO: reg_rdata         = cnt[0];
            A_CNT_HI: reg_rdata         = cnt[1];
            A_RLD_LO: reg_rdata         = st_q.rld[0];
            A_RLD_HI: reg_rdata         = st_q.rld[1];
            default:  reg_rdata         = '0;
        endcase
    end

    assign irq = (st_q.ctrl.flag_hi | (st_q.ctrl.flag_lo & st_q.ctrl.lo_irq_en))
               & st_q.ctrl.irq_en;
    assign lo_ovf_pulse = ovf_pulse[0];
    assign hi_ovf_pulse = ovf_pulse[1];
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq,
    input logic         lo_pulse,
    input logic         hi_pulse,
    input logic         flag_lo,
    input logic         flag_hi,
    input logic         irq_en,
    input logic         run_hi,
    input logic         active,
    input logic         wr_lo,
    input logic         wr_hi,
    input logic [W-1:0] cnt_lo,
    input logic [W-1:0] cnt_hi
);
    assert_lo_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !wr_lo) |=> (cnt_lo == $past(cnt_lo)));

    assert_hi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_hi && !wr_hi) |=> (cnt_hi == $past(cnt_hi)));

    assert_lo_pulse_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_pulse |-> flag_lo);

    assert_hi_pulse_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_pulse |-> flag_hi);

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_irq_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && flag_hi) |-> irq);
endmodule

bind split_reload_timer srt_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .lo_pulse(lo_ovf_pulse),
    .hi_pulse(hi_ovf_pulse),
    .flag_lo (st_q.ctrl.flag_lo),
    .flag_hi (st_q.ctrl.flag_hi),
    .irq_en  (st_q.ctrl.irq_en),
    .run_hi  (cnt_en[1] | ~split_active ? st_q.ctrl.run_hi & split_active : 1'b0),
    .active  (split_active),
    .wr_lo   (cnt_wr[0]),
    .wr_hi   (cnt_wr[1]),
    .cnt_lo  (cnt[0]),
    .cnt_hi  (cnt[1])
);

// File: tb/split_reload_timer_tb.sv
module split_reload_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ext_clk = 1'b0;
    logic       irq, lo_ovf_pulse, hi_ovf_pulse;

    int total = 0;
    int bad   = 0;

    split_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
        .irq(irq), .lo_ovf_pulse(lo_ovf_pulse), .hi_ovf_pulse(hi_ovf_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // CTRL bits: 0 split, 1 capture, 2 run, 3 ext_sel, 4 lo_irq_en, 5 irq_en, 6 lo flag, 7 hi flag
    typedef struct packed {
        logic       run;
        logic       lo_ie;
        logic [7:0] lo0;
        logic [7:0] hi0;
        logic [7:0] lo_rld;
        logic [7:0] hi_rld;
        logic [7:0] ncyc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b1, 8'hFE, 8'hFD, 8'h10, 8'h20, 8'd5},
        '{1'b0, 1'b1, 8'hF0, 8'h80, 8'h00, 8'h00, 8'd20},
        '{1'b1, 1'b0, 8'h00, 8'hFF, 8'hAA, 8'h55, 8'd3},
        '{1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'd1},
        '{1'b1, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'd1},
        '{1'b1, 1'b1, 8'hFE, 8'hFE, 8'hFE, 8'hFE, 8'd40}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] mlo, mhi;
        logic       flo, fhi;
        int         plo, phi, elo, ehi;

        idle(3);
        #1 rst_n = 1'b1;

        // R10 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R10 reset reg", v, 0);
        end
        check("R10 reset irq", irq, 0);
        check("R10 reset pulses", {lo_ovf_pulse, hi_ovf_pulse}, 0);

        // vector table: fast clocks on both halves, model computes expectations
        foreach (VECS[k]) begin
            wr(3'd0, 8'h00);
            wr(3'd1, 8'h03);                        // R4 both fast
            wr(3'd2, VECS[k].lo0);
            wr(3'd3, VECS[k].hi0);
            wr(3'd4, VECS[k].lo_rld);
            wr(3'd5, VECS[k].hi_rld);
            wr(3'd0, {2'b00, 1'b1, VECS[k].lo_ie, 1'b0, VECS[k].run, 1'b0, 1'b1});
            mlo = VECS[k].lo0; mhi = VECS[k].hi0;
            flo = 1'b0; fhi = 1'b0; elo = 0; ehi = 0; plo = 0; phi = 0;
            for (int i = 0; i < int'(VECS[k].ncyc); i++) begin
                if (mlo == 8'hFF) begin mlo = VECS[k].lo_rld; flo = 1'b1; elo++; end
                else mlo = mlo + 8'd1;
                if (VECS[k].run) begin
                    if (mhi == 8'hFF) begin mhi = VECS[k].hi_rld; fhi = 1'b1; ehi++; end
                    else mhi = mhi + 8'd1;
                end
                @(negedge clk);
                plo += int'(lo_ovf_pulse);
                phi += int'(hi_ovf_pulse);
            end
            rd(3'd2, v); check("R2 R3 R4 low count", v, mlo);
            rd(3'd3, v); check("R2 R3 R4 high count", v, mhi);
            rd(3'd0, v);
            check("R7 low flag", v[6], flo);
            check("R7 high flag", v[7], fhi);
            check("R8 irq", irq, int'(fhi | (flo & VECS[k].lo_ie)));
            check("R2 low pulses", plo, elo);
            check("R2 high pulses", phi, ehi);
        end

        // R9 write collides with tick
        wr(3'd0, 8'h05);
        wr(3'd2, 8'h42);
        rd(3'd2, v); check("R9 write wins", v, 8'h42);
        idle(1);
        rd(3'd2, v); check("R9 next tick", v, 8'h43);

        // R1 capture set or split clear freezes both
        wr(3'd0, 8'h07);                            // split+capture+run
        rd(3'd2, mlo); rd(3'd3, mhi);
        idle(10);
        rd(3'd2, v); check("R1 capture freezes low", v, mlo);
        rd(3'd3, v); check("R1 capture freezes high", v, mhi);
        wr(3'd0, 8'h04);                            // run only, split off
        idle(10);
        rd(3'd2, v); check("R1 split off low", v, mlo);

        // R7 sticky and clear; R8 gating
        wr(3'd0, 8'h00);
        wr(3'd2, 8'hFF);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h01);                            // split, run off, irq off
        idle(50);
        rd(3'd0, v); check("R7 low flag sticky", v[6], 1);
        check("R8 irq disabled", irq, 0);
        wr(3'd0, 8'h31);                            // irq_en + lo_irq_en, flags cleared
        rd(3'd0, v); check("R7 flag cleared", v[6], 0);
        check("R8 irq after clear", irq, 0);

        // R5 divide by 12
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h01);
        idle(24);
        rd(3'd2, v); check("R5 div12 low", v, 2);
        rd(3'd3, v); check("R3 high stopped", v, 0);

        // R6 external clock divided by 8
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h09);                            // split + ext_sel
        for (int e = 0; e < 16; e++) begin
            ext_clk = 1'b1; idle(3);
            ext_clk = 1'b0; idle(3);
        end
        idle(6);
        rd(3'd2, v); check("R6 ext div8 low", v, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule